// File: doc/BRIEF.md
# Command-Register I2C Bus Controller

This block is an I2C bus master driven through one 16-bit command/data register. A single full-word write carries a start request, a stop request, an acknowledge level and a data byte. The controller tracks a mode (slave receiver, master transmitter, master receiver). It decodes the start/stop pair against that mode. It then runs the matching bus sequence on the open-drain SCL/SDA lines, one byte at a time, using a fixed clock divider.

After the ninth clock of each byte the controller raises its interrupt and holds SCL low. Software services the byte and writes the register again. That write clears the interrupt and releases SCL for the next action. A start request issued while idle sends a START followed by an address byte. Bit 0 of that byte is the direction and picks the next mode. The same request issued while a transfer is in progress produces a repeated START. A stop request ends the transfer and returns the controller to slave-receiver mode.

The write port carries `wr_valid` and `wr_ready`. A write is taken only in a cycle where both are high. `wr_ready` is low while a bus sequence is running, so software must hold the write until it rises. Reads are combinational and need no handshake.

Top module: `i2c_cmd_ctrl`

## Requirements
- R1: After reset the command register and receive register read as zero, mode is slave receiver (code 0), both bus lines are released, `irq` is low and `wr_ready` is high.
- R2: A write takes effect only when `wr_be` is 2'b11. A write with any other byte-enable leaves the register, the mode, the interrupt and the bus unchanged.
- R3: `wr_ready` is low from the cycle after an accepted write that starts a bus sequence until that sequence reaches the idle or held state.
- R4: Read address 0 returns {5'b0, start bit (10), stop bit (9), ack bit (8), data byte (7:0)}. Address 1 returns {8'b0, received byte}. Each read byte lane whose `rd_be` bit is 0 returns zero.
- R5: In a master mode, a write with start/stop bits 00 or 11 transfers one byte with no START or STOP, and the mode is unchanged. In slave-receiver mode the same write causes no bus activity.
- R6: Start=1/stop=0 in slave-receiver mode produces a START (SDA falling while SCL is high) and then sends the data byte. The new mode is master transmitter (code 1) if data bit 0 is 0, or master receiver (code 2) if it is 1.
- R7: Start=1/stop=0 in a master mode produces a repeated START with no STOP before it, sends the byte, and sets the mode from data bit 0 as in R6.
- R8: Start=0/stop=1 in a master mode produces a STOP (SDA rising while SCL is high). The mode returns to slave receiver and both lines are released. In slave-receiver mode this write causes no bus activity.
- R9: Transmitted bytes appear on SDA most significant bit first. SDA changes only while SCL is low, except at START and STOP.
- R10: On the ninth clock the controller releases SDA when transmitting. When receiving it drives SDA to the ack bit last written (0 = low = acknowledge).
- R11: In master-receiver mode the byte on SDA is captured MSB first into the receive register, which is readable at address 1.
- R12: After the ninth clock `irq` rises with SCL held low and SDA released. Both remain so until an accepted full-word write, after which `irq` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Controller can take a write (idle or held) |
| wr_be | input | 2 | Write byte enables; only 2'b11 is honoured |
| wr_data | input | 16 | Command/data word |
| rd_addr | input | 1 | 0 = command register, 1 = receive register |
| rd_be | input | 2 | Read byte-lane enables |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Byte-complete interrupt |
| mode | output | 2 | Current mode: 0 slave receiver, 1 master transmitter, 2 master receiver |
| scl_drive_low | output | 1 | Open-drain SCL pull-down enable |
| sda_drive_low | output | 1 | Open-drain SDA pull-down enable |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The bound checker checks several rules on every cycle. While `irq` is high, SCL is held low and SDA is released. An accepted word write clears `irq` in the next cycle. A partial write changes neither mode nor readiness. The idle slave-receiver state keeps both lines released, and the mode code always stays legal. What a cycle-local property cannot show is left to the bench scenarios, which watch the lines through a bus monitor and a small slave model. These cover the START/STOP and repeated-START patterns, the bit order of sent and received bytes, the ninth-clock acknowledge level, and the mode chosen by the direction bit.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'd0,
    MODE_MST_TX = 2'd1,
    MODE_MST_RX = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_START,
    ACT_BYTE,
    ACT_STOP
  } act_e;

  typedef enum logic [3:0] {
    EN_IDLE,
    EN_HOLD,
    EN_S0,
    EN_S1,
    EN_S2,
    EN_BIT,
    EN_TAIL,
    EN_P0,
    EN_P1,
    EN_P2,
    EN_P3
  } eng_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CMD_W  = BYTE_W + 3;

  // field order matches bit positions 10..0 of the word
  typedef struct packed {
    logic              sta;
    logic              sto;
    logic              ack;
    logic [BYTE_W-1:0] data;
  } cmd_t;

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int unsigned QTR_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_cmd_pkg::*;
(
  input  mode_e cur_mode,
  input  logic  sta,
  input  logic  sto,
  input  logic  dir_bit,
  output act_e  act,
  output mode_e next_mode,
  output logic  tx_dir
);
  always_comb begin
    act       = ACT_NONE;
    next_mode = cur_mode;
    tx_dir    = 1'b0;
    if (sta && !sto) begin
      act       = ACT_START;
      next_mode = dir_bit ? MODE_MST_RX : MODE_MST_TX;
      tx_dir    = 1'b1;
    end else if (!sta && sto) begin
      if (cur_mode != MODE_SLV_RX) begin
        act       = ACT_STOP;
        next_mode = MODE_SLV_RX;
      end
    end else if (cur_mode != MODE_SLV_RX) begin
      act    = ACT_BYTE;
      tx_dir = (cur_mode == MODE_MST_TX);
    end
  end
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  cmd_t              wr_cmd,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_addr,
  input  logic [1:0]        rd_be,
  output cmd_t              cmd_q,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned LANE_W = WORD_W / 2;

  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (wr_fire) begin
      cmd_q <= wr_cmd;
    end
  end

  always_comb begin
    if (rd_addr) word = WORD_W'(rx_byte);
    else         word = WORD_W'(cmd_q);
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign rd_data[g*LANE_W +: LANE_W] = rd_be[g] ? word[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  act_e              act,
  input  logic              tx_dir,
  input  logic              ack_lvl,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_i,
  output logic              run,
  output logic              ready,
  output logic              irq,
  output logic              scl_low,
  output logic              sda_low,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int unsigned BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] ACK_IDX = BW'(BYTE_W);

  eng_e              st;
  logic [BW-1:0]     bit_idx;
  logic [1:0]        qtr;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] rxsh;
  logic              is_tx;
  logic              ack_drive;
  logic              sda_q;
  logic              irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= EN_IDLE;
      bit_idx   <= '0;
      qtr       <= '0;
      shreg     <= '0;
      rxsh      <= '0;
      rx_byte   <= '0;
      is_tx     <= 1'b0;
      ack_drive <= 1'b0;
      sda_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else if (go) begin
      irq_q     <= 1'b0;
      shreg     <= tx_byte;
      is_tx     <= tx_dir;
      ack_drive <= !ack_lvl;
      bit_idx   <= '0;
      qtr       <= '0;
      unique case (act)
        ACT_START: st <= EN_S0;
        ACT_BYTE:  st <= EN_BIT;
        ACT_STOP:  st <= EN_P0;
        default:   st <= st;
      endcase
    end else if (tick) begin
      unique case (st)
        EN_S0: st <= EN_S1;
        EN_S1: begin
          sda_q <= 1'b1;            // SDA falls while SCL high: START
          st    <= EN_S2;
        end
        EN_S2: st <= EN_BIT;
        EN_BIT: begin
          qtr <= qtr + 1'b1;
          unique case (qtr)
            2'd0: begin
              if (bit_idx == ACK_IDX) sda_q <= is_tx ? 1'b0 : ack_drive;
              else                    sda_q <= is_tx ? !shreg[BYTE_W-1] : 1'b0;
            end
            2'd2: begin
              if (!is_tx && bit_idx != ACK_IDX) rxsh <= {rxsh[BYTE_W-2:0], sda_i};
            end
            2'd3: begin
              if (bit_idx == ACK_IDX) begin
                st <= EN_TAIL;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
        EN_TAIL: begin
          sda_q <= 1'b0;
          irq_q <= 1'b1;
          if (!is_tx) rx_byte <= rxsh;
          st <= EN_HOLD;
        end
        EN_P0: begin
          sda_q <= 1'b1;
          st    <= EN_P1;
        end
        EN_P1: st <= EN_P2;
        EN_P2: begin
          sda_q <= 1'b0;            // SDA rises while SCL high: STOP
          st    <= EN_P3;
        end
        EN_P3: st <= EN_IDLE;
        default: st <= st;
      endcase
    end
  end

  assign ready   = (st == EN_IDLE) || (st == EN_HOLD);
  assign run     = !ready;
  assign irq     = irq_q;
  assign sda_low = sda_q;

  always_comb begin
    unique case (st)
      EN_S0, EN_TAIL, EN_HOLD, EN_P0, EN_P1: scl_low = 1'b1;
      EN_BIT:                                scl_low = !qtr[1];
      default:                               scl_low = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned QTR_CYC = 125,
  parameter int unsigned WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_addr,
  input  logic [1:0]        rd_be,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq,
  output logic [1:0]        mode,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              sda_i
);
  cmd_t              wr_cmd;
  cmd_t              cmd_q;
  logic              wr_fire;
  mode_e             mode_q;
  mode_e             mode_n;
  act_e              act;
  logic              tx_dir;
  logic              tick;
  logic              run;
  logic [BYTE_W-1:0] rx_byte;
  logic              unused_wr_hi;

  assign wr_cmd       = cmd_t'(wr_data[CMD_W-1:0]);
  assign unused_wr_hi = ^wr_data[WORD_W-1:CMD_W];
  assign wr_fire      = wr_valid && wr_ready && (&wr_be);

  i2c_cmd_decode u_dec (
    .cur_mode  (mode_q),
    .sta       (wr_cmd.sta),
    .sto       (wr_cmd.sto),
    .dir_bit   (wr_cmd.data[0]),
    .act       (act),
    .next_mode (mode_n),
    .tx_dir    (tx_dir)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_SLV_RX;
    else if (wr_fire) mode_q <= mode_n;
  end

  i2c_cmd_regs #(.WORD_W(WORD_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_cmd  (wr_cmd),
    .rx_byte (rx_byte),
    .rd_addr (rd_addr),
    .rd_be   (rd_be),
    .cmd_q   (cmd_q),
    .rd_data (rd_data)
  );

  i2c_qtick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  i2c_seq_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .go      (wr_fire),
    .act     (act),
    .tx_dir  (tx_dir),
    .ack_lvl (wr_cmd.ack),
    .tx_byte (wr_cmd.data),
    .sda_i   (sda_i),
    .run     (run),
    .ready   (wr_ready),
    .irq     (irq),
    .scl_low (scl_drive_low),
    .sda_low (sda_drive_low),
    .rx_byte (rx_byte)
  );

  assign mode = mode_q;
endmodule

// File: rtl/i2c_cmd_ctrl_chk.sv
module i2c_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [1:0] wr_be,
  input logic       irq,
  input logic [1:0] mode,
  input logic       scl_drive_low,
  input logic       sda_drive_low
);
  // R12: held byte keeps SCL low and SDA released
  assert_irq_holds_scl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (scl_drive_low && !sda_drive_low));

  // R12: accepted full write clears the interrupt
  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_be == 2'b11) |=> !irq);

  // R2: partial write changes neither mode nor readiness
  assert_partial_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_be != 2'b11) |=> ($stable(mode) && wr_ready));

  // R3: no interrupt while a sequence runs
  assert_busy_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !irq);

  // R8: idle slave receiver leaves both lines released
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && wr_ready) |-> (!scl_drive_low && !sda_drive_low && !irq));

  // R6: only legal mode codes
  assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

bind i2c_cmd_ctrl i2c_cmd_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_be         (wr_be),
  .irq           (irq),
  .mode          (mode),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_cmd_ctrl_test.sv
`timescale 1ns/1ps
module i2c_cmd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [1:0]  rd_be = 2'b11;
  logic [15:0] rd_data;
  logic        irq;
  logic [1:0]  mode;
  logic        scl_low;
  logic        sda_low;
  logic        slv_low = 1'b0;
  logic        scl_line;
  logic        sda_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_line = !scl_low;
  assign sda_line = !(sda_low || slv_low);

  i2c_cmd_ctrl #(.QTR_CYC(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr), .rd_be(rd_be),
    .rd_data(rd_data), .irq(irq), .mode(mode), .scl_drive_low(scl_low),
    .sda_drive_low(sda_low), .sda_i(sda_line)
  );

  // bus monitor and slave model
  int       start_cnt = 0;
  int       stop_cnt = 0;
  int       fall_cnt = 0;
  int       bitn = 0;
  int       nbyte = 0;
  logic [7:0] cap = '0;
  logic     ack_seen = 1'b1;
  bit       rd_active = 1'b0;
  bit       slave_nack = 1'b0;

  always @(negedge sda_line) if (scl_line) begin
    start_cnt++; bitn = 0; nbyte = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    stop_cnt++; bitn = 0; nbyte = 0;
  end
  always @(posedge scl_line) begin
    if (bitn < 8) begin
      cap = {cap[6:0], sda_line};
      bitn++;
    end else begin
      ack_seen = sda_line;
      if (nbyte == 0) rd_active = cap[0];
      else if (rd_active && sda_line) rd_active = 1'b0;
      bitn = 0;
      nbyte++;
    end
  end
  always @(negedge scl_line) begin
    logic [7:0] sb;
    fall_cnt++;
    sb = (nbyte == 1) ? 8'hA5 : 8'h3C;
    if (rd_active && nbyte >= 1 && bitn < 8) slv_low <= !sb[7 - bitn];
    else if (bitn == 8 && (nbyte == 0 || !rd_active)) slv_low <= !slave_nack;
    else slv_low <= 1'b0;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_be = 2'b00;
  endtask

  task automatic rd(input logic a, input logic [1:0] be, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a; rd_be = be;
    #1 v = rd_data;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !wr_ready; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 scl", scl_low, 0);
    check("R1 sda", sda_low, 0);
    check("R1 irq", irq, 0);
    check("R1 mode", mode, 0);
    check("R1 ready", wr_ready, 1);
    rd(1'b0, 2'b11, v); check("R1 cmd reg", v, 0);
    rd(1'b1, 2'b11, v); check("R1 rx reg", v, 0);
  endtask

  task automatic t_idle_noop();
    int f0 = fall_cnt;
    int p0 = stop_cnt;
    logic [15:0] v;
    wr(2'b11, 16'h0355);
    check("R8 ready after stop in slave mode", wr_ready, 1);
    repeat (40) @(negedge clk);
    check("R8 no stop in slave mode", stop_cnt, p0);
    check("R8 no scl activity", fall_cnt, f0);
    check("R8 mode", mode, 0);
    rd(1'b0, 2'b11, v); check("R4 cmd readback", v, 16'h0355);
    wr(2'b11, 16'h0100);
    repeat (40) @(negedge clk);
    check("R5 no activity for byte write in slave mode", fall_cnt, f0);
    check("R5 irq stays low", irq, 0);
  endtask

  task automatic t_partial();
    int s0 = start_cnt;
    logic [15:0] v;
    wr(2'b01, 16'h04A4);
    repeat (40) @(negedge clk);
    rd(1'b0, 2'b11, v); check("R2 register unchanged", v, 16'h0100);
    check("R2 no start", start_cnt, s0);
    check("R2 mode", mode, 0);
  endtask

  task automatic t_start();
    int s0 = start_cnt;
    wr(2'b11, 16'h05A4);
    check("R3 busy after start", wr_ready, 0);
    wait_irq();
    check("R6 start seen", start_cnt, s0 + 1);
    check("R6 R9 address byte", cap, 8'hA4);
    check("R6 slave ack", ack_seen, 0);
    check("R6 mode master tx", mode, 1);
    check("R12 irq", irq, 1);
    check("R12 scl held", scl_low, 1);
    check("R12 sda released", sda_low, 0);
  endtask

  task automatic t_bytes();
    int s0 = start_cnt;
    int p0 = stop_cnt;
    wr(2'b10, 16'h015A);
    repeat (30) @(negedge clk);
    check("R2 partial in hold keeps irq", irq, 1);
    check("R12 scl still held", scl_low, 1);
    wr(2'b11, 16'h015A);
    check("R12 irq cleared", irq, 0);
    wait_irq();
    check("R9 msb first 5A", cap, 8'h5A);
    check("R5 mode kept (00)", mode, 1);
    wr(2'b11, 16'h07C3);
    wait_irq();
    check("R9 byte C3", cap, 8'hC3);
    check("R5 mode kept (11)", mode, 1);
    check("R5 no start", start_cnt, s0);
    check("R5 no stop", stop_cnt, p0);
    slave_nack = 1'b1;
    wr(2'b11, 16'h0100);
    wait_irq();
    check("R10 tx releases sda on ninth", ack_seen, 1);
    slave_nack = 1'b0;
  endtask

  task automatic t_rstart();
    int s0 = start_cnt;
    int p0 = stop_cnt;
    wr(2'b11, 16'h0549);
    wait_irq();
    check("R7 repeated start", start_cnt, s0 + 1);
    check("R7 no stop", stop_cnt, p0);
    check("R7 address", cap, 8'h49);
    check("R7 mode master rx", mode, 2);
  endtask

  task automatic t_read();
    logic [15:0] v;
    wr(2'b11, 16'h0000);
    wait_irq();
    rd(1'b1, 2'b11, v); check("R11 rx A5", v, 16'h00A5);
    check("R10 ack low", ack_seen, 0);
    rd(1'b1, 2'b10, v); check("R4 rx upper lane", v, 0);
    wr(2'b11, 16'h0100);
    wait_irq();
    rd(1'b1, 2'b01, v); check("R11 rx 3C", v, 16'h003C);
    check("R10 nack high", ack_seen, 1);
    rd(1'b0, 2'b10, v); check("R4 cmd upper lane", v, 16'h0100);
    rd(1'b0, 2'b01, v); check("R4 cmd lower lane", v, 16'h0000);
    check("R5 mode kept rx", mode, 2);
  endtask

  task automatic t_stop();
    int p0 = stop_cnt;
    wr(2'b11, 16'h0200);
    wait_ready();
    repeat (2) @(negedge clk);
    check("R8 stop seen", stop_cnt, p0 + 1);
    check("R8 mode slave", mode, 0);
    check("R8 scl released", scl_low, 0);
    check("R8 sda released", sda_low, 0);
    check("R8 irq low", irq, 0);
  endtask

  task automatic t_start_rx();
    wr(2'b11, 16'h04A1);
    wait_irq();
    check("R6 address A1", cap, 8'hA1);
    check("R6 mode master rx", mode, 2);
    t_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_noop();
    t_partial();
    t_start();
    t_bytes();
    t_rstart();
    t_read();
    t_stop();
    t_start_rx();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule